// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Bank

This block controls a bank of 32 general-purpose pins through a small word-addressed register bus. Each pin has an output latch and a direction bit. Three write-only ports update the latch atomically by setting, clearing or inverting only the bits written as 1. A 2-bit routing code per pin picks the source of both the pad output value and the pad output enable. The source is either the pin's own latch and direction bit, or one of three peripheral channels.

Every pin input passes through a synchronizer and then a per-pin qualification state machine. A level reaches the rest of the block only after it has held for a set number of consecutive samples. The qualified level is returned when the data address is read. The same level drives the shared peripheral input bus, whatever routing code is selected. Pads, pull-ups and open-drain behaviour sit outside the block. It drives only `pad_out` and `pad_oe`.

The qualifier has two states. `Q_STEADY` means the synchronized level equals the qualified level. A mismatch takes it to `Q_CHANGING` with a sample count of 1. In `Q_CHANGING`, a return to the qualified level goes back to `Q_STEADY` (the glitch is dropped). While the mismatch persists, the count rises. When the count reaches `QUAL_SAMPLES`-1 on a further mismatching sample, the qualified level takes the new value and the machine returns to `Q_STEADY` (the level is accepted).

Top module: `gpio_bank`

## Requirements
- R1: After reset, all direction bits, routing codes and latch bits are 0. `pad_oe` and `pad_out` are all 0, and reads of addresses 4, 5 and 6 return 0.
- R2: A write to address 0 loads the whole latch. With routing code 00, `pad_out[i]` equals latch bit i.
- R3: A write to address 1 sets the latch bits where the write data is 1 and leaves the others unchanged.
- R4: A write to address 2 clears the latch bits where the write data is 1 and leaves the others unchanged.
- R5: A write to address 3 inverts the latch bits where the write data is 1 and leaves the others unchanged.
- R6: Address 4 holds the direction bits (1 = output, 0 = input). With routing code 00, `pad_oe[i]` equals direction bit i, so an input pin is high impedance.
- R7: Address 5 holds the routing codes of pins 0–15, and address 6 holds those of pins 16–31. The code of pin i sits at bits [2(i mod 16)+1 : 2(i mod 16)]. Code 00 selects the latch and direction bit. Codes 01, 10 and 11 route `pN_out[i]` and `pN_oe[i]` of peripheral 1, 2 and 3 to the pad.
- R8: A read of address 0 returns the qualified pin levels, not the latch.
- R9: `periph_in` always carries the qualified pin levels, whatever the routing codes are.
- R10: With the default `QUAL_SAMPLES`=3 and two synchronizer stages, a new level on `pin_in` is still not visible after 4 rising edges and is visible after the 5th. A level that lasts 2 cycles never appears, and one that lasts 3 cycles does.
- R11: Reads of addresses 1, 2, 3 and 7 return 0. A write to address 7 changes no latch, direction or routing bit.
- R12: Read data appears on `bus_rdata` one cycle after the read request and stays there until the next read. Addresses 4, 5 and 6 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Output enable to the pads |
| p1_out | input | 32 | Peripheral 1 output values |
| p1_oe | input | 32 | Peripheral 1 output enables |
| p2_out | input | 32 | Peripheral 2 output values |
| p2_oe | input | 32 | Peripheral 2 output enables |
| p3_out | input | 32 | Peripheral 3 output values |
| p3_oe | input | 32 | Peripheral 3 output enables |
| periph_in | output | 32 | Qualified pin levels shared by all peripherals |

## Verification
The latch ports are driven with sequences of data, set, clear and toggle writes whose operands are a spread of arithmetic patterns. This separates an operation that touches only the masked bits from one that overwrites or ignores the rest. Routing is swept with all pins on one code, for each of the four codes, and then with the mixed per-pin codes (i+k) mod 4. This exposes swapped peripherals, swapped code values and fields shifted between the low and high words. On the input side, a steady change, a 2-cycle pulse and a 3-cycle pulse are applied. These tell apart correct latency, glitch rejection and acceptance at exactly the qualification length, while the latch is held at a different value from the pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NPINS  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 3'd0,
        A_SET   = 3'd1,
        A_CLR   = 3'd2,
        A_TGL   = 3'd3,
        A_DIR   = 3'd4,
        A_MUXLO = 3'd5,
        A_MUXHI = 3'd6,
        A_RSVD  = 3'd7
    } reg_addr_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_GPIO = 2'd0,
        SRC_P1   = 2'd1,
        SRC_P2   = 2'd2,
        SRC_P3   = 2'd3
    } src_e;

    typedef enum logic {
        Q_STEADY   = 1'b0,
        Q_CHANGING = 1'b1
    } qual_state_e;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [N-1:0]          latch_q,
    output logic [N-1:0]          dir_q,
    output logic [SEL_W*N-1:0]    mux_q
);

    localparam int HALF = DATA_W;

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            mux_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                A_DATA:  latch_q <= wdata;
                A_SET:   latch_q <= latch_q | wdata;
                A_CLR:   latch_q <= latch_q & ~wdata;
                A_TGL:   latch_q <= latch_q ^ wdata;
                A_DIR:   dir_q   <= wdata;
                A_MUXLO: mux_q[HALF-1:0]    <= wdata;
                A_MUXHI: mux_q[2*HALF-1:HALF] <= wdata;
                default: ;
            endcase
        end
    end

    AST_SET_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_SET) |=> (latch_q == ($past(latch_q) | $past(wdata)))); // R3
    AST_CLR_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_CLR) |=> (latch_q == ($past(latch_q) & ~$past(wdata)))); // R4
    AST_TGL_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_TGL) |=> (latch_q == ($past(latch_q) ^ $past(wdata)))); // R5
    AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_RSVD) |=> ($stable(latch_q) && $stable(dir_q) && $stable(mux_q))); // R11

endmodule

// File: rtl/gpio_pin_qual.sv
module gpio_pin_qual
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_qual
);

    localparam int CNT_W = $clog2(QUAL_SAMPLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_SAMPLES - 1);

    logic pin_sync;

    // synchronizer depth chosen by parameter
    generate
        if (SYNC_STAGES <= 1) begin : g_sync_one
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= pin_raw;
            end
            assign pin_sync = s_q;
        end else begin : g_sync_chain
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC_STAGES-2:0], pin_raw};
            end
            assign pin_sync = s_q[SYNC_STAGES-1];
        end
    endgenerate

    qual_state_e state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic qual_q, qual_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_STEADY;
            cnt_q   <= '0;
            qual_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            qual_q  <= qual_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        qual_n  = qual_q;
        unique case (state_q)
            Q_STEADY: begin
                cnt_n = '0;
                if (pin_sync != qual_q) begin
                    if (QUAL_SAMPLES <= 1) begin
                        qual_n = pin_sync;
                    end else begin
                        state_n = Q_CHANGING;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            Q_CHANGING: begin
                if (pin_sync == qual_q) begin
                    state_n = Q_STEADY;
                    cnt_n   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_n = Q_STEADY;
                    cnt_n   = '0;
                    qual_n  = pin_sync;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: state_n = Q_STEADY;
        endcase
    end

    assign pin_qual = qual_q;

    AST_QUAL_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_q != $past(qual_q)) |-> (QUAL_SAMPLES <= 1 || $past(state_q) == Q_CHANGING)); // R10
    AST_QUAL_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(QUAL_SAMPLES)); // R10

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
    import gpio_bank_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic [N-1:0]       latch_q,
    input  logic [N-1:0]       dir_q,
    input  logic [SEL_W*N-1:0] mux_q,
    input  logic [N-1:0]       p1_out,
    input  logic [N-1:0]       p1_oe,
    input  logic [N-1:0]       p2_out,
    input  logic [N-1:0]       p2_oe,
    input  logic [N-1:0]       p3_out,
    input  logic [N-1:0]       p3_oe,
    output logic [N-1:0]       pad_out,
    output logic [N-1:0]       pad_oe
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            src_e code;
            assign code = src_e'(mux_q[SEL_W*i +: SEL_W]);
            always_comb begin
                unique case (code)
                    SRC_GPIO: begin pad_out[i] = latch_q[i]; pad_oe[i] = dir_q[i]; end
                    SRC_P1:   begin pad_out[i] = p1_out[i];  pad_oe[i] = p1_oe[i]; end
                    SRC_P2:   begin pad_out[i] = p2_out[i];  pad_oe[i] = p2_oe[i]; end
                    SRC_P3:   begin pad_out[i] = p3_out[i];  pad_oe[i] = p3_oe[i]; end
                    default:  begin pad_out[i] = 1'b0;       pad_oe[i] = 1'b0;     end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe,
    input  logic [31:0] p1_out,
    input  logic [31:0] p1_oe,
    input  logic [31:0] p2_out,
    input  logic [31:0] p2_oe,
    input  logic [31:0] p3_out,
    input  logic [31:0] p3_oe,
    output logic [31:0] periph_in
);

    localparam int N = NPINS;

    logic [N-1:0]       latch_q;
    logic [N-1:0]       dir_q;
    logic [SEL_W*N-1:0] mux_q;
    logic [N-1:0]       pin_q;
    logic               wr_en;
    logic               rd_en;
    reg_addr_e          sel;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;
    assign sel   = reg_addr_e'(bus_addr);

    gpio_regfile #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .mux_q   (mux_q)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_qual
            gpio_pin_qual #(
                .SYNC_STAGES  (SYNC_STAGES),
                .QUAL_SAMPLES (QUAL_SAMPLES)
            ) u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_raw  (pin_in[i]),
                .pin_qual (pin_q[i])
            );
        end
    endgenerate

    gpio_out_mux #(.N(N)) u_mux (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .mux_q   (mux_q),
        .p1_out  (p1_out),
        .p1_oe   (p1_oe),
        .p2_out  (p2_out),
        .p2_oe   (p2_oe),
        .p3_out  (p3_out),
        .p3_oe   (p3_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign periph_in = pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            unique case (sel)
                A_DATA:  bus_rdata <= pin_q;
                A_DIR:   bus_rdata <= dir_q;
                A_MUXLO: bus_rdata <= mux_q[DATA_W-1:0];
                A_MUXHI: bus_rdata <= mux_q[2*DATA_W-1:DATA_W];
                default: bus_rdata <= '0;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_INPUT_PIN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
                (mux_q[SEL_W*i +: SEL_W] == SRC_GPIO && !dir_q[i]) |-> !pad_oe[i]); // R6
        end
    endgenerate

    AST_WRITEONLY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == A_SET || sel == A_CLR || sel == A_TGL || sel == A_RSVD))
        |=> (bus_rdata == '0)); // R11
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, periph_in;
    logic [31:0] p1_out = 32'hA5A5_5A5A, p1_oe = 32'hFF00_FF00;
    logic [31:0] p2_out = 32'h3C3C_C3C3, p2_oe = 32'h0F0F_F0F0;
    logic [31:0] p3_out = 32'h6996_9669, p3_oe = 32'hCCCC_3333;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_latch = '0;
    logic [31:0] exp_dir = '0;
    logic [63:0] exp_mux = '0;

    always #5 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .p1_out(p1_out), .p1_oe(p1_oe), .p2_out(p2_out), .p2_oe(p2_oe),
        .p3_out(p3_out), .p3_oe(p3_oe), .periph_in(periph_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic exp_pads(output logic [31:0] eo, output logic [31:0] eoe);
        for (int i = 0; i < 32; i++) begin
            case (exp_mux[2*i +: 2])
                2'd0: begin eo[i] = exp_latch[i]; eoe[i] = exp_dir[i]; end
                2'd1: begin eo[i] = p1_out[i];    eoe[i] = p1_oe[i];   end
                2'd2: begin eo[i] = p2_out[i];    eoe[i] = p2_oe[i];   end
                default: begin eo[i] = p3_out[i]; eoe[i] = p3_oe[i];   end
            endcase
        end
    endtask

    task automatic chk_pads(input string req);
        logic [31:0] eo, eoe;
        exp_pads(eo, eoe);
        chk({req, " pad_out"}, pad_out, eo);
        chk({req, " pad_oe"}, pad_oe, eoe);
    endtask

    task automatic set_mux(input logic [63:0] m);
        wr(3'd5, m[31:0]);
        wr(3'd6, m[63:32]);
        exp_mux = m;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r, v, pat;
        logic seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        rd(3'd4, r); chk("R1 dir", r, 32'h0);
        rd(3'd5, r); chk("R1 mux lo", r, 32'h0);
        rd(3'd6, r); chk("R1 mux hi", r, 32'h0);

        // R6 / R12 direction
        wr(3'd4, 32'hFFFF_FFFF); exp_dir = 32'hFFFF_FFFF;
        rd(3'd4, r); chk("R12 dir readback", r, exp_dir);
        chk_pads("R6 all out");

        // R2 whole-latch writes
        for (int k = 0; k < 6; k++) begin
            v = 32'h9E37_79B9 * (k + 1) ^ (32'h1 << (k * 5));
            wr(3'd0, v); exp_latch = v;
            chk_pads("R2 data write");
        end

        // R3 R4 R5 masked updates
        for (int k = 0; k < 12; k++) begin
            v = (32'h8531_2EB7 * (k + 3)) ^ (32'hF0F0_0000 >> k);
            case (k % 3)
                0: begin wr(3'd1, v); exp_latch = exp_latch | v;  chk_pads("R3 set"); end
                1: begin wr(3'd2, v); exp_latch = exp_latch & ~v; chk_pads("R4 clear"); end
                default: begin wr(3'd3, v); exp_latch = exp_latch ^ v; chk_pads("R5 toggle"); end
            endcase
        end
        wr(3'd1, 32'h0); chk_pads("R3 set zero mask");
        wr(3'd2, 32'h0); chk_pads("R4 clear zero mask");
        wr(3'd3, 32'hFFFF_FFFF); exp_latch = ~exp_latch; chk_pads("R5 toggle all");

        // R6 partial direction: inputs must be Hi-Z
        wr(3'd4, 32'h0F0F_00FF); exp_dir = 32'h0F0F_00FF;
        chk_pads("R6 mixed dir");

        // R7 uniform codes then mixed codes
        for (int c = 0; c < 4; c++) begin
            set_mux({32{c[1:0]}});
            chk_pads("R7 uniform code");
            rd(3'd5, r); chk("R12 mux lo readback", r, exp_mux[31:0]);
            rd(3'd6, r); chk("R12 mux hi readback", r, exp_mux[63:32]);
        end
        for (int k = 0; k < 4; k++) begin
            logic [63:0] m;
            for (int i = 0; i < 32; i++) m[2*i +: 2] = 2'((i + k) % 4);
            set_mux(m);
            chk_pads("R7 mixed code");
        end
        set_mux(64'h0);

        // R8 R9 qualified input path
        pat = 32'h1234_ABCD;
        pin_in = pat;
        repeat (8) @(negedge clk);
        rd(3'd0, r); chk("R8 data reads pins", r, pat);
        chk("R9 periph_in gpio mode", periph_in, pat);
        set_mux({32{2'b11}});
        pin_in = ~pat;
        repeat (8) @(negedge clk);
        chk("R9 periph_in code 11", periph_in, ~pat);
        rd(3'd0, r); chk("R8 data under code 11", r, ~pat);
        set_mux({32{2'b01}});
        chk("R9 periph_in code 01", periph_in, ~pat);
        set_mux(64'h0);

        // R10 latency: old after 4 edges, new after 5th
        pat = 32'hF00D_0FF0;
        pin_in = pat;
        repeat (4) @(negedge clk);
        chk("R10 not yet after 4 edges", periph_in, ~32'h1234_ABCD);
        @(negedge clk);
        chk("R10 visible after 5 edges", periph_in, pat);

        // R10 two-cycle pulse rejected
        pin_in = ~pat;
        seen = 1'b0;
        repeat (2) @(negedge clk);
        pin_in = pat;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (periph_in !== pat) seen = 1'b1;
        end
        chk("R10 2-cycle pulse ignored", 32'(seen), 32'h0);

        // R10 three-cycle pulse accepted
        pin_in = ~pat;
        seen = 1'b0;
        repeat (3) @(negedge clk);
        pin_in = pat;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (periph_in === ~pat) seen = 1'b1;
        end
        chk("R10 3-cycle pulse accepted", 32'(seen), 32'h1);
        repeat (6) @(negedge clk);
        chk("R10 settles back", periph_in, pat);

        // R11 reserved and write-only addresses
        wr(3'd7, 32'hFFFF_FFFF);
        chk_pads("R11 reserved write");
        rd(3'd4, r); chk("R11 dir after reserved write", r, exp_dir);
        rd(3'd5, r); chk("R11 mux after reserved write", r, 32'h0);
        rd(3'd1, r); chk("R11 read set", r, 32'h0);
        rd(3'd2, r); chk("R11 read clear", r, 32'h0);
        rd(3'd3, r); chk("R11 read toggle", r, 32'h0);
        rd(3'd7, r); chk("R11 read reserved", r, 32'h0);

        // R12 read data holds
        rd(3'd4, r);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds", bus_rdata, exp_dir);

        finish_run();
    end

endmodule